// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one external bus cycle at a time for a 16-bit processor with a 20-bit address space. The bus uses a single set of 16 lines for both the address and the data. A request carries the following: the address, the direction, the memory-or-I/O select, the byte-or-word select, a 2-bit segment code and the write data. The block then moves through the states T1, T2, T3, zero or more Tw, and T4. It drives the shared lines, the four upper address/status lines and the address latch strobe. It also drives the read and write strobes, the memory/IO indicator, the high-byte enable, and the enable and direction controls for the external data transceivers.

Each bus state lasts two clocks of `clk_i`, a first half and a second half. This allows the data enable, the read strobe and the write-data hold to change halfway through a state. A word access at an odd address is refused with a one-clock error pulse, and no bus cycle starts. Read data is captured when the last T3/Tw ends, aligned to the low lane for byte reads, and reported with a one-clock done pulse.

Top module: `mbus_seq`

## Requirements
- R1: `ale_o` is high for both halves of T1 and low at all other times. It is always driven, and while it is high no strobe or data enable is active.
- R2: In T1, `ad_oe_o` is 1 and `ad_o` carries address bits 15:0. `a_hi_o` carries address bits 19:16 for a memory request (`req_mem_i`=1) and 0000 for an I/O request.
- R3: From T2 through T4, `a_hi_o` = {0, `ie_flag_i`, segment[1:0]`}`, and the interrupt-enable bit follows the input clock by clock.
- R4: In a read, `ad_oe_o` is 0 from T2 through T4. `rd_n_o` is low from the second half of T2 until the end of the last T3/Tw, and high everywhere else.
- R5: In a write, `wr_n_o` is low throughout T2, T3 and every Tw. `ad_o` carries the write data with `ad_oe_o`=1 from T2 until the end of the first half of T4. `rd_n_o` and `wr_n_o` are never low together.
- R6: `den_n_o` is low from the second half of T2 to the end of the first half of T4, and high otherwise.
- R7: `mio_o` (1 = memory) and `dtr_o` (1 = transmit, write) are loaded when a request is accepted. They stay constant through the cycle and afterwards, until the next accepted request.
- R8: `bhe_n_o` is low in T1 when the upper lane is used, which means a word access or a byte access with address bit 0 = 1. It is high otherwise.
- R9: `ready_i` is sampled at the end of T3 and at the end of each Tw. A low value inserts one more Tw of two clocks.
- R10: `ad_i` is captured at the end of the last T3/Tw. For a word read, `rdata_o` = `ad_i`. For a byte read at an even address, `rdata_o` = {8'h00, `ad_i`[7:0]}. For a byte read at an odd address, `rdata_o` = {8'h00, `ad_i`[15:8]}.
- R11: `done_o` is a one-clock pulse in the clock after T4 ends. Counted from the accepting edge, that is 8 clocks plus 2 per wait state.
- R12: A word request at an odd address starts no cycle. `err_o` pulses for one clock after the accepting edge, and `busy_o` stays low.
- R13: A request presented while a cycle is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, two per bus state |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present (taken when idle) |
| req_addr_i | input | 20 | Request address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mem_i | input | 1 | 1 = memory, 0 = I/O |
| req_byte_i | input | 1 | 1 = byte, 0 = word |
| req_seg_i | input | 2 | Segment code shown in the status bits |
| req_wdata_i | input | 16 | Write data |
| ie_flag_i | input | 1 | Interrupt-enable flag shown in the status bits |
| ready_i | input | 1 | Device ready, active high |
| ad_i | input | 16 | Shared lines, inbound |
| ad_o | output | 16 | Shared lines, outbound |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| a_hi_o | output | 4 | Upper address in T1, status from T2 on |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| den_n_o | output | 1 | Transceiver enable, active low |
| dtr_o | output | 1 | Transceiver direction, 1 = transmit |
| mio_o | output | 1 | 1 = memory, 0 = I/O |
| bhe_n_o | output | 1 | High-byte enable, active low |
| busy_o | output | 1 | Bus cycle in progress |
| rdata_o | output | 16 | Aligned read data |
| done_o | output | 1 | Cycle complete pulse |
| err_o | output | 1 | Misaligned word rejection pulse |

## Verification
The bench builds the block with its default parameters: a 20-bit address and a 16-bit data path, which leaves four upper address/status lines. With that width, a single test can reach all of the following:
- memory and I/O address forms on the upper lines;
- both byte lanes for reads and for the high-byte enable;
- wait-state runs of one to three states;
- the status interrupt bit changing partway through a cycle.

The bench also covers a misaligned word request and a request offered while a cycle is in progress.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bus_st_e;
endpackage

// File: rtl/mbus_timing.sv
module mbus_timing
  import mbus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    ready_i,
  output bus_st_e st_o,
  output logic    ph_o,
  output logic    cap_o,
  output logic    done_o
);
  bus_st_e st_q, st_d;
  logic    ph_q, done_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (start_i) st_d = ST_T1;
      ST_T1:        st_d = ST_T2;
      ST_T2:        st_d = ST_T3;
      ST_T3, ST_TW: st_d = ready_i ? ST_T4 : ST_TW;
      ST_T4:        st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  // each bus state spans two clocks; ph_q marks the second half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= (st_q == ST_T4) && ph_q;
      if (st_q == ST_IDLE) begin
        ph_q <= 1'b0;
        st_q <= st_d;
      end else begin
        ph_q <= ~ph_q;
        if (ph_q) st_q <= st_d;
      end
    end
  end

  assign st_o   = st_q;
  assign ph_o   = ph_q;
  assign cap_o  = ph_q && ready_i && (st_q == ST_T3 || st_q == ST_TW);
  assign done_o = done_q;
endmodule

// File: rtl/mbus_lane.sv
module mbus_lane #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              cap_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_mem_i,
  input  logic              req_byte_i,
  input  logic [1:0]        req_seg_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic              misalign_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic              mem_o,
  output logic [1:0]        seg_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              hi_lane_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HALF = DATA_W / 2;

  logic byte_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      write_o <= 1'b0;
      mem_o   <= 1'b0;
      seg_o   <= '0;
      wdata_o <= '0;
      byte_q  <= 1'b0;
    end else if (load_i) begin
      addr_o  <= req_addr_i;
      write_o <= req_write_i;
      mem_o   <= req_mem_i;
      seg_o   <= req_seg_i;
      wdata_o <= req_wdata_i;
      byte_q  <= req_byte_i;
    end
  end

  // bytes land on the low lane; odd address takes the upper half
  always_comb begin
    rdata_d = ad_i;
    if (byte_q) begin
      rdata_d = '0;
      rdata_d[HALF-1:0] = addr_o[0] ? ad_i[DATA_W-1:HALF] : ad_i[HALF-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (cap_i) rdata_q <= rdata_d;
  end

  assign misalign_o = ~req_byte_i & req_addr_i[0];
  assign hi_lane_o  = ~byte_q | addr_o[0];
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  bus_st_e           st_i,
  input  logic              ph_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              mem_i,
  input  logic [1:0]        seg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              hi_lane_i,
  input  logic              ie_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   a_hi_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              den_n_o,
  output logic              bhe_n_o
);
  logic in_t1, data_ph, strobe_ph, t4_first, t2_second;
  logic [HI_W-1:0] status;

  always_comb begin
    status = '0;
    status[HI_W-2] = ie_i;
    status[1:0]    = seg_i;
  end

  assign in_t1     = (st_i == ST_T1);
  assign data_ph   = (st_i == ST_T2) || (st_i == ST_T3) || (st_i == ST_TW) || (st_i == ST_T4);
  assign strobe_ph = (st_i == ST_T2) || (st_i == ST_T3) || (st_i == ST_TW);
  assign t4_first  = (st_i == ST_T4) && !ph_i;
  assign t2_second = (st_i == ST_T2) && ph_i;

  assign ale_o   = in_t1;
  assign ad_oe_o = in_t1 || (write_i && (strobe_ph || t4_first));
  assign ad_o    = in_t1 ? addr_i[DATA_W-1:0] : (write_i ? wdata_i : '0);
  assign a_hi_o  = in_t1 ? (mem_i ? addr_i[ADDR_W-1:DATA_W] : '0)
                 : (data_ph ? status : '0);
  // read strobe waits for the lines to float in the first half of T2
  assign rd_n_o  = !(!write_i && (t2_second || st_i == ST_T3 || st_i == ST_TW));
  assign wr_n_o  = !(write_i && strobe_ph);
  assign den_n_o = !(t2_second || st_i == ST_T3 || st_i == ST_TW || t4_first);
  assign bhe_n_o = !(in_t1 && hi_lane_i);
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              req_mem_i,
  input  logic              req_byte_i,
  input  logic [1:0]        req_seg_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ie_flag_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [HI_W-1:0]   a_hi_o,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              den_n_o,
  output logic              dtr_o,
  output logic              mio_o,
  output logic              bhe_n_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o
);
  bus_st_e st;
  logic ph, cap, misalign, start, err_q, write_q, mem_q, hi_lane;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0] seg_q;

  assign busy_o = (st != ST_IDLE);
  assign start  = !busy_o && req_valid_i && !misalign;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= !busy_o && req_valid_i && misalign;
  end
  assign err_o = err_q;

  mbus_timing u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .ready_i (ready_i),
    .st_o    (st),
    .ph_o    (ph),
    .cap_o   (cap),
    .done_o  (done_o)
  );

  mbus_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lane (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .cap_i       (cap),
    .req_addr_i  (req_addr_i),
    .req_write_i (req_write_i),
    .req_mem_i   (req_mem_i),
    .req_byte_i  (req_byte_i),
    .req_seg_i   (req_seg_i),
    .req_wdata_i (req_wdata_i),
    .ad_i        (ad_i),
    .misalign_o  (misalign),
    .addr_o      (addr_q),
    .write_o     (write_q),
    .mem_o       (mem_q),
    .seg_o       (seg_q),
    .wdata_o     (wdata_q),
    .hi_lane_o   (hi_lane),
    .rdata_o     (rdata_o)
  );

  mbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .st_i      (st),
    .ph_i      (ph),
    .addr_i    (addr_q),
    .write_i   (write_q),
    .mem_i     (mem_q),
    .seg_i     (seg_q),
    .wdata_i   (wdata_q),
    .hi_lane_i (hi_lane),
    .ie_i      (ie_flag_i),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .a_hi_o    (a_hi_o),
    .ale_o     (ale_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .den_n_o   (den_n_o),
    .bhe_n_o   (bhe_n_o)
  );

  assign mio_o = mem_q;
  assign dtr_o = write_q;
endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ale_o,
  input logic ad_oe_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic den_n_o,
  input logic mio_o,
  input logic dtr_o,
  input logic bhe_n_o,
  input logic busy_o,
  input logic done_o,
  input logic err_o
);
  assert_ale_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ad_oe_o && rd_n_o && wr_n_o && den_n_o);

  assert_ale_two_clk_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ale_o) |=> ale_o);

  assert_rd_floats_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> !ad_oe_o && busy_o);

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_n_o || wr_n_o);

  assert_den_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !den_n_o |-> busy_o && !ale_o);

  assert_ctl_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mio_o) && $stable(dtr_o));

  assert_bhe_t1_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bhe_n_o |-> ale_o);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_err_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o && !done_o);
endmodule

bind mbus_seq mbus_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ale_o   (ale_o),
  .ad_oe_o (ad_oe_o),
  .rd_n_o  (rd_n_o),
  .wr_n_o  (wr_n_o),
  .den_n_o (den_n_o),
  .mio_o   (mio_o),
  .dtr_o   (dtr_o),
  .bhe_n_o (bhe_n_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/mbus_seq_test.sv
module mbus_seq_test;
  typedef struct packed {
    logic        err;
    logic        rd;
    logic [15:0] data;
  } item_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic [19:0] req_addr_i = '0;
  logic req_write_i = 1'b0, req_mem_i = 1'b0, req_byte_i = 1'b0;
  logic [1:0] req_seg_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic ie_flag_i = 1'b0;
  logic ready_i = 1'b1;
  logic [15:0] ad_i = '0;
  logic [15:0] ad_o, rdata_o;
  logic [3:0] a_hi_o;
  logic ad_oe_o, ale_o, rd_n_o, wr_n_o, den_n_o, dtr_o, mio_o, bhe_n_o, busy_o, done_o, err_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;
  item_t q[$];

  always #10 clk_i = ~clk_i;

  mbus_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .req_write_i(req_write_i), .req_mem_i(req_mem_i), .req_byte_i(req_byte_i),
    .req_seg_i(req_seg_i), .req_wdata_i(req_wdata_i), .ie_flag_i(ie_flag_i),
    .ready_i(ready_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .a_hi_o(a_hi_o),
    .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .den_n_o(den_n_o), .dtr_o(dtr_o),
    .mio_o(mio_o), .bhe_n_o(bhe_n_o), .busy_o(busy_o), .rdata_o(rdata_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // monitor: pops the scoreboard on every completion or rejection
  always @(negedge clk_i) begin
    if (rst_ni && (done_o || err_o)) begin
      if (q.size() == 0) begin
        chk("R13 unexpected completion", {done_o, err_o}, 0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk("R12 err flag", err_o, it.err);
        chk("R11 done flag", done_o, !it.err);
        if (!it.err && it.rd) chk("R10 rdata", rdata_o, it.data);
      end
    end
  end

  task automatic run_cycle(input logic [19:0] a, input logic w, input logic m, input logic b,
                           input logic [1:0] sg, input logic [15:0] wd, input int waits,
                           input logic [15:0] bus, input logic poke);
    item_t it;
    logic hi;
    hi = !b || a[0];
    it.err = 1'b0;
    it.rd = !w;
    it.data = !b ? bus : (a[0] ? {8'h00, bus[15:8]} : {8'h00, bus[7:0]});
    q.push_back(it);
    req_valid_i = 1; req_addr_i = a; req_write_i = w; req_mem_i = m;
    req_byte_i = b; req_seg_i = sg; req_wdata_i = wd; ready_i = 1;
    @(negedge clk_i);                       // T1 first half
    req_valid_i = 0;
    chk("R1 ale in T1", ale_o, 1);
    chk("R2 oe in T1", ad_oe_o, 1);
    chk("R2 addr low", ad_o, a[15:0]);
    chk("R2 addr high", a_hi_o, m ? a[19:16] : 4'h0);
    chk("R8 bhe", bhe_n_o, !hi);
    chk("R7 mio", mio_o, m);
    chk("R7 dtr", dtr_o, w);
    @(negedge clk_i);                       // T1 second half
    chk("R1 ale T1 second half", ale_o, 1);
    @(negedge clk_i);                       // T2 first half
    chk("R1 ale after T1", ale_o, 0);
    chk("R3 status T2", a_hi_o, {1'b0, ie_flag_i, sg});
    chk("R4 rd_n before float done", rd_n_o, 1);
    chk("R6 den_n first half T2", den_n_o, 1);
    chk("R5 wr_n T2", wr_n_o, !w);
    chk("R8 bhe outside T1", bhe_n_o, 1);
    chk("R4 oe T2", ad_oe_o, w);
    if (poke) begin
      req_valid_i = 1; req_addr_i = a ^ 20'h00100; req_write_i = !w;
    end
    @(negedge clk_i);                       // T2 second half
    req_valid_i = 0;
    chk("R4 rd_n T2 second half", rd_n_o, w);
    chk("R6 den_n T2 second half", den_n_o, 0);
    if (w) chk("R5 wdata", ad_o, wd);
    ie_flag_i = !ie_flag_i;
    @(negedge clk_i);                       // T3 first half
    chk("R3 status follows ie", a_hi_o, {1'b0, ie_flag_i, sg});
    ready_i = (waits == 0);
    ad_i = bus;
    @(negedge clk_i);                       // T3 second half
    for (int i = 0; i < waits; i++) begin
      @(negedge clk_i);                     // Tw first half
      chk("R9 strobe held in Tw", {rd_n_o, wr_n_o}, w ? 2'b10 : 2'b01);
      chk("R9 busy in Tw", busy_o, 1);
      if (i == waits - 1) ready_i = 1;
      @(negedge clk_i);                     // Tw second half
    end
    @(negedge clk_i);                       // T4 first half
    chk("R4 rd_n T4", rd_n_o, 1);
    chk("R5 wr_n T4", wr_n_o, 1);
    chk("R6 den_n T4 first half", den_n_o, 0);
    chk("R5 data held T4 first half", ad_oe_o, w);
    chk("R9 not done yet", done_o, 0);
    @(negedge clk_i);                       // T4 second half
    chk("R6 den_n T4 second half", den_n_o, 1);
    chk("R5 oe released mid T4", ad_oe_o, 0);
    chk("R7 mio held", mio_o, m);
    @(negedge clk_i);                       // idle, done pulse
    chk("R11 done timing", done_o, 1);
    chk("R11 busy cleared", busy_o, 0);
  endtask

  task automatic run_err(input logic [19:0] a);
    item_t it;
    it.err = 1'b1; it.rd = 1'b0; it.data = '0;
    q.push_back(it);
    req_valid_i = 1; req_addr_i = a; req_byte_i = 0; req_write_i = 0; req_mem_i = 1;
    @(negedge clk_i);
    req_valid_i = 0;
    chk("R12 err pulse", err_o, 1);
    chk("R12 no cycle", busy_o, 0);
    @(negedge clk_i);
    chk("R12 err single", err_o, 0);
    chk("R12 still idle", ale_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset ale", ale_o, 0);
    chk("R4 reset rd_n", rd_n_o, 1);
    chk("R5 reset wr_n", wr_n_o, 1);
    chk("R6 reset den_n", den_n_o, 1);
    chk("R11 reset busy", busy_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    run_cycle(20'hA1234, 0, 1, 0, 2'd2, 16'h0000, 0, 16'hBEEF, 0);
    run_cycle(20'h56788, 1, 1, 0, 2'd1, 16'h1357, 2, 16'h0000, 0);
    run_cycle(20'h003F1, 0, 0, 1, 2'd3, 16'h0000, 1, 16'hC3A5, 1);   // R13 poke
    @(negedge clk_i);
    chk("R13 poke ignored", busy_o, 0);
    run_cycle(20'hF0010, 1, 1, 1, 2'd0, 16'h00AB, 0, 16'h0000, 0);
    @(negedge clk_i);
    chk("R7 mio idle hold", mio_o, 1);
    chk("R7 dtr idle hold", dtr_o, 1);
    run_cycle(20'h12340, 0, 1, 1, 2'd2, 16'h0000, 3, 16'h77AA, 0);
    run_err(20'h00005);
    run_cycle(20'h00100, 1, 0, 0, 2'd0, 16'h4242, 0, 16'h0000, 0);
    repeat (4) @(negedge clk_i);
    chk("R11 scoreboard drained", q.size(), 0);
    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!ended) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R11 watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule